// File: doc/BRIEF.md
# Display Interrupt Status Controller

This block gathers single-cycle event pulses from a multi-channel display DMA engine and keeps them as sticky flags in two status words. The first word holds global events and the channel-0 events. The second word holds start-of-frame, end-of-frame, branch and input-underrun flags for channels 1 and up. Two control words supply a mask bit for each event. A single level-sensitive interrupt line is registered and is high whenever any flag is set while its mask bit is clear.

Software uses a small register bus to program the two control words. It clears status flags by writing ones (write-one-to-clear) and reads an interrupt-identifier register. The identifier register holds the frame ID of the channel that raised the first unmasked frame, branch or bus-error event. If a later event of that kind arrives while the line is already high, the identifier register is kept and a "subsequent interrupt" flag is set. A bus error also records the number of the failing channel in a 3-bit field of the first status word.

The word addresses on `bus_addr` are: 0 for control word A, 1 for control word B, 2 for status word A, 3 for status word B, and 4 for the identifier register. Any other address reads as zero and ignores writes. `NUM_CH` may be set from 2 to 7. `ID_W` may be at most 32.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After reset, every register reads as zero and `irq` is low.
- R2: Control word A keeps only bits [26:0] of a write. Control word B keeps the write value AND 0x3F3F3F3F.
- R3: A pulse sets its flag in status word A at the next clock edge: last-frame-done bit0, channel-0 start-of-frame bit1, AC-bias bit3, underrun channel 0 bit4, underrun channel 1 bit5, output underrun bit6, channel-0 end-of-frame bit8, channel-0 branch bit9, read status bit11, command bit12. Bits 31 and 27:13 always read 0.
- R4: For a channel ch of 1 or more, status word B sets start-of-frame at bit ch-1, end-of-frame at bit ch+7 and branch at bit ch+15. For ch of 2 or more it also sets input underrun at bit ch+23.
- R5: A write to status word A clears each of bits [11:0] where the written value has a 1. Writing 1 in bit2 also clears the channel field [30:28]. Bit12 is not cleared by a write.
- R6: A write to status word B clears only the bits in (value AND 0x3E3F3F). Bit16 and bits 29:24 survive any write.
- R7: A bus-error pulse on channel ch sets status A bit2 and loads ch into [30:28].
- R8: A write to control word A that takes the stored bit0 from 1 to 0 sets status A bit7.
- R9: `irq` is registered: at each edge it becomes high exactly when a status flag was set with its mask clear. The mask bits in control word A are: bit3 for last-frame-done, bit4 for start-of-frame 0, bit5 for underrun 0, bit6 for end-of-frame 0, bit11 for quick-disable, bit20 for branch 0, bit21 for output underrun, bit23 for read status, bit24 for command. Control word B bit24 masks underrun channel 1. A bus error has no mask. Bits 3 and 10 never raise the line. Each status B bit is masked by the control B bit at the same position.
- R10: A qualifying event is an unmasked start-of-frame, end-of-frame or branch pulse, or any bus-error pulse. If one arrives while `irq` is low, the identifier register loads the frame ID of the lowest-numbered channel involved. If `irq` is high, status A bit10 is set and the identifier register is kept.
- R11: Writes to the identifier register have no effect.
- R12: If an event pulse and a clearing write hit the same flag in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_sof | input | NUM_CH | Start-of-frame pulse per channel |
| ev_eof | input | NUM_CH | End-of-frame pulse per channel |
| ev_brn | input | NUM_CH | Branch-taken pulse per channel |
| ev_iu | input | NUM_CH | Input-underrun pulse per channel |
| ev_berr | input | 1 | Bus-error pulse |
| ev_berr_ch | input | 3 | Channel number of the bus error |
| ev_lastdone | input | 1 | Last frame done pulse |
| ev_acbias | input | 1 | AC-bias count pulse |
| ev_outrun | input | 1 | Output underrun pulse |
| ev_rdstat | input | 1 | Panel read-status pulse |
| ev_cmd | input | 1 | Command-done pulse |
| frame_ids | input | NUM_CH*ID_W | Current frame ID per channel, channel 0 in the low bits |
| irq | output | 1 | Registered interrupt level |

## Verification
The bench builds the block with `NUM_CH` = 7 and `ID_W` = 32. With these values every status B lane exists, including the non-clearable branch lane of channel 1 and the channel 2 to 6 underrun lanes. The bus-error channel field can then take every value from 0 to 6. Full 32-bit frame IDs make a wrong channel selection in the identifier register show up in any bit position.

// File: rtl/dic_pkg.sv
package dic_pkg;

  typedef enum logic [2:0] {
    DIC_A_CTRLA = 3'd0,
    DIC_A_CTRLB = 3'd1,
    DIC_A_STATA = 3'd2,
    DIC_A_STATB = 3'd3,
    DIC_A_IDENT = 3'd4
  } dic_addr_e;

  localparam int unsigned STATA_LO_W = 13;

  // status word A bit positions
  localparam int unsigned SA_LAST = 0;
  localparam int unsigned SA_SOF0 = 1;
  localparam int unsigned SA_BERR = 2;
  localparam int unsigned SA_ACB  = 3;
  localparam int unsigned SA_IU0  = 4;
  localparam int unsigned SA_IU1  = 5;
  localparam int unsigned SA_OUR  = 6;
  localparam int unsigned SA_QDIS = 7;
  localparam int unsigned SA_EOF0 = 8;
  localparam int unsigned SA_BRN0 = 9;
  localparam int unsigned SA_SUBQ = 10;
  localparam int unsigned SA_RDST = 11;
  localparam int unsigned SA_CMD  = 12;
  localparam int unsigned SA_CH_LSB = 28;

  // mask positions inside control word A
  localparam int unsigned CA_ENABLE = 0;
  localparam int unsigned CA_M_LAST = 3;
  localparam int unsigned CA_M_SOF0 = 4;
  localparam int unsigned CA_M_IU0  = 5;
  localparam int unsigned CA_M_EOF0 = 6;
  localparam int unsigned CA_M_QDIS = 11;
  localparam int unsigned CA_M_BRN0 = 20;
  localparam int unsigned CA_M_OUR  = 21;
  localparam int unsigned CA_M_RDST = 23;
  localparam int unsigned CA_M_CMD  = 24;
  // control word B mask for underrun of channel 1 (lives in status A)
  localparam int unsigned CB_M_IU1  = 24;

  localparam logic [31:0] CTRLA_KEEP = 32'h07FF_FFFF;
  localparam logic [31:0] CTRLB_KEEP = 32'h3F3F_3F3F;
  localparam logic [31:0] STATB_CLR  = 32'h003E_3F3F;
  localparam logic [11:0] STATA_CLR  = 12'hFFF;

endpackage

// File: rtl/dic_event_map.sv
module dic_event_map #(
  parameter int unsigned NUM_CH = 7
) (
  input  logic [NUM_CH-1:0] ev_sof,
  input  logic [NUM_CH-1:0] ev_eof,
  input  logic [NUM_CH-1:0] ev_brn,
  input  logic [NUM_CH-1:0] ev_iu,
  input  logic              ev_berr,
  input  logic [2:0]        ev_berr_ch,
  input  logic              ev_lastdone,
  input  logic              ev_acbias,
  input  logic              ev_outrun,
  input  logic              ev_rdstat,
  input  logic              ev_cmd,
  input  logic              m_sof0,
  input  logic              m_eof0,
  input  logic              m_brn0,
  input  logic [21:0]       ctrlb_lo,
  output logic [12:0]       sa_set,
  output logic [31:0]       sb_set,
  output logic [NUM_CH-1:0] qual
);
  import dic_pkg::*;

  always_comb begin
    sa_set          = '0;
    sa_set[SA_LAST] = ev_lastdone;
    sa_set[SA_SOF0] = ev_sof[0];
    sa_set[SA_BERR] = ev_berr;
    sa_set[SA_ACB]  = ev_acbias;
    sa_set[SA_IU0]  = ev_iu[0];
    sa_set[SA_IU1]  = ev_iu[1];
    sa_set[SA_OUR]  = ev_outrun;
    sa_set[SA_EOF0] = ev_eof[0];
    sa_set[SA_BRN0] = ev_brn[0];
    sa_set[SA_RDST] = ev_rdstat;
    sa_set[SA_CMD]  = ev_cmd;
  end

  always_comb begin
    sb_set = '0;
    for (int ch = 1; ch < NUM_CH; ch++) begin
      sb_set[ch-1]  = ev_sof[ch];
      sb_set[ch+7]  = ev_eof[ch];
      sb_set[ch+15] = ev_brn[ch];
      if (ch >= 2) sb_set[ch+23] = ev_iu[ch];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_qual
    logic berr_hit;
    assign berr_hit = ev_berr && (ev_berr_ch == 3'(ch));
    if (ch == 0) begin : g_lane0
      assign qual[ch] = (ev_sof[ch] & ~m_sof0) | (ev_eof[ch] & ~m_eof0) |
                        (ev_brn[ch] & ~m_brn0) | berr_hit;
    end else begin : g_lanen
      assign qual[ch] = (ev_sof[ch] & ~ctrlb_lo[ch-1]) |
                        (ev_eof[ch] & ~ctrlb_lo[ch+7]) |
                        (ev_brn[ch] & ~ctrlb_lo[ch+15]) | berr_hit;
    end
  end

endmodule

// File: rtl/dic_ident.sv
module dic_ident #(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned ID_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        qual,
  input  logic                     irq_q,
  input  logic [NUM_CH*ID_W-1:0]   frame_ids,
  output logic [ID_W-1:0]          ident_q,
  output logic                     subq_set
);
  logic [ID_W-1:0] pick;
  logic            any_qual;
  logic            ident_en;

  always_comb begin
    pick = '0;
    for (int ch = NUM_CH - 1; ch >= 0; ch--) begin
      if (qual[ch]) pick = frame_ids[ch*ID_W +: ID_W];
    end
  end

  assign any_qual = |qual;
  assign ident_en = any_qual & ~irq_q;
  assign subq_set = any_qual & irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ident_q <= '0;
    end else if (ident_en) begin
      ident_q <= pick;
    end
  end

endmodule

// File: rtl/dic_irq.sv
module dic_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [12:0] sa_lo,
  input  logic [12:0] sa_mask,
  input  logic [31:0] sb,
  input  logic [31:0] ctrlb,
  output logic        irq_q
);
  logic level;

  always_comb begin
    level = (|(sa_lo & ~sa_mask)) | (|(sb & ~ctrlb));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= level;
  end

endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl #(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned ID_W   = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [2:0]             bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NUM_CH-1:0]      ev_sof,
  input  logic [NUM_CH-1:0]      ev_eof,
  input  logic [NUM_CH-1:0]      ev_brn,
  input  logic [NUM_CH-1:0]      ev_iu,
  input  logic                   ev_berr,
  input  logic [2:0]             ev_berr_ch,
  input  logic                   ev_lastdone,
  input  logic                   ev_acbias,
  input  logic                   ev_outrun,
  input  logic                   ev_rdstat,
  input  logic                   ev_cmd,
  input  logic [NUM_CH*ID_W-1:0] frame_ids,
  output logic                   irq
);
  import dic_pkg::*;

  logic [31:0] ctrla_q, ctrla_d, ctrlb_q, ctrlb_d;
  logic [12:0] sa_lo_q, sa_lo_d;
  logic [2:0]  sa_ch_q, sa_ch_d;
  logic [31:0] sb_q, sb_d;
  logic        ctrla_en, ctrlb_en, sa_en, sb_en;
  logic [12:0] sa_set_ev, sa_set, sa_clr, sa_mask;
  logic [31:0] sb_set, sb_clr;
  logic [NUM_CH-1:0] qual;
  logic        qdis_set, subq_set, irq_q;
  logic [ID_W-1:0] ident_q;
  logic [31:0] stata;

  assign ctrla_en = bus_wr && (bus_addr == DIC_A_CTRLA);
  assign ctrlb_en = bus_wr && (bus_addr == DIC_A_CTRLB);
  assign sa_en    = 1'b1;
  assign sb_en    = 1'b1;

  // per-bit mask for status word A; bits 3 and 10 never raise the line
  always_comb begin
    sa_mask          = '0;
    sa_mask[SA_LAST] = ctrla_q[CA_M_LAST];
    sa_mask[SA_SOF0] = ctrla_q[CA_M_SOF0];
    sa_mask[SA_BERR] = 1'b0;
    sa_mask[SA_ACB]  = 1'b1;
    sa_mask[SA_IU0]  = ctrla_q[CA_M_IU0];
    sa_mask[SA_IU1]  = ctrlb_q[CB_M_IU1];
    sa_mask[SA_OUR]  = ctrla_q[CA_M_OUR];
    sa_mask[SA_QDIS] = ctrla_q[CA_M_QDIS];
    sa_mask[SA_EOF0] = ctrla_q[CA_M_EOF0];
    sa_mask[SA_BRN0] = ctrla_q[CA_M_BRN0];
    sa_mask[SA_SUBQ] = 1'b1;
    sa_mask[SA_RDST] = ctrla_q[CA_M_RDST];
    sa_mask[SA_CMD]  = ctrla_q[CA_M_CMD];
  end

  dic_event_map #(.NUM_CH(NUM_CH)) u_map (
    .ev_sof      (ev_sof),
    .ev_eof      (ev_eof),
    .ev_brn      (ev_brn),
    .ev_iu       (ev_iu),
    .ev_berr     (ev_berr),
    .ev_berr_ch  (ev_berr_ch),
    .ev_lastdone (ev_lastdone),
    .ev_acbias   (ev_acbias),
    .ev_outrun   (ev_outrun),
    .ev_rdstat   (ev_rdstat),
    .ev_cmd      (ev_cmd),
    .m_sof0      (sa_mask[SA_SOF0]),
    .m_eof0      (sa_mask[SA_EOF0]),
    .m_brn0      (sa_mask[SA_BRN0]),
    .ctrlb_lo    (ctrlb_q[21:0]),
    .sa_set      (sa_set_ev),
    .sb_set      (sb_set),
    .qual        (qual)
  );

  dic_ident #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_ident (
    .clk       (clk),
    .rst_n     (rst_n),
    .qual      (qual),
    .irq_q     (irq_q),
    .frame_ids (frame_ids),
    .ident_q   (ident_q),
    .subq_set  (subq_set)
  );

  dic_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .sa_lo   (sa_lo_q),
    .sa_mask (sa_mask),
    .sb      (sb_q),
    .ctrlb   (ctrlb_q),
    .irq_q   (irq_q)
  );

  assign qdis_set = ctrla_en && ctrla_q[CA_ENABLE] && !bus_wdata[CA_ENABLE];

  // next state: set beats clear
  always_comb begin
    ctrla_d = bus_wdata & CTRLA_KEEP;
    ctrlb_d = bus_wdata & CTRLB_KEEP;

    sa_set          = sa_set_ev;
    sa_set[SA_QDIS] = qdis_set;
    sa_set[SA_SUBQ] = subq_set;
    sa_clr          = '0;
    if (bus_wr && (bus_addr == DIC_A_STATA)) sa_clr[11:0] = bus_wdata[11:0] & STATA_CLR;
    sa_lo_d = (sa_lo_q & ~sa_clr) | sa_set;

    sa_ch_d = sa_ch_q;
    if (bus_wr && (bus_addr == DIC_A_STATA) && bus_wdata[SA_BERR]) sa_ch_d = '0;
    if (ev_berr) sa_ch_d = ev_berr_ch;

    sb_clr = '0;
    if (bus_wr && (bus_addr == DIC_A_STATB)) sb_clr = bus_wdata & STATB_CLR;
    sb_d = (sb_q & ~sb_clr) | sb_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrla_q <= '0;
      ctrlb_q <= '0;
      sa_lo_q <= '0;
      sa_ch_q <= '0;
      sb_q    <= '0;
    end else begin
      if (ctrla_en) ctrla_q <= ctrla_d;
      if (ctrlb_en) ctrlb_q <= ctrlb_d;
      if (sa_en) begin
        sa_lo_q <= sa_lo_d;
        sa_ch_q <= sa_ch_d;
      end
      if (sb_en) sb_q <= sb_d;
    end
  end

  assign stata = {1'b0, sa_ch_q, 15'b0, sa_lo_q};

  always_comb begin
    case (bus_addr)
      DIC_A_CTRLA: bus_rdata = ctrla_q;
      DIC_A_CTRLB: bus_rdata = ctrlb_q;
      DIC_A_STATA: bus_rdata = stata;
      DIC_A_STATB: bus_rdata = sb_q;
      DIC_A_IDENT: bus_rdata = 32'(ident_q);
      default:     bus_rdata = '0;
    endcase
  end

  assign irq = irq_q;

endmodule

// File: rtl/dic_checker.sv
module dic_checker #(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned ID_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [2:0]        bus_addr,
  input logic              wdata_b0,
  input logic [NUM_CH-1:0] ev_sof,
  input logic [NUM_CH-1:0] ev_eof,
  input logic [NUM_CH-1:0] ev_brn,
  input logic              ev_berr,
  input logic [2:0]        ev_berr_ch,
  input logic              ctrla_en_bit,
  input logic [31:0]       stata,
  input logic [31:0]       statb,
  input logic [ID_W-1:0]   ident,
  input logic              irq
);
  logic frame_evt;
  assign frame_evt = (|ev_sof) | (|ev_eof) | (|ev_brn) | ev_berr;

  // R7: bus error lands in bit2 with its channel number
  a_r7_berr_field: assert property (@(posedge clk) disable iff (!rst_n)
    ev_berr |=> (stata[2] && stata[30:28] == $past(ev_berr_ch)));

  // R8: enable falling by write raises quick-disable
  a_r8_quick_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && ctrla_en_bit && !wdata_b0) |=> stata[7]);

  // R12: a channel-0 start-of-frame pulse always lands
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sof[0] |=> stata[1]);

  // R6: branch lane of channel 1 is never cleared by a write
  a_r6_sticky_lane: assert property (@(posedge clk) disable iff (!rst_n)
    statb[16] |=> statb[16]);

  // R10: identifier held while the line is high
  a_r10_ident_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> $stable(ident));

  // R11: identifier ignores writes
  a_r11_ident_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4 && !frame_evt) |=> $stable(ident));

  // R9: no flags, no interrupt on the next edge
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stata == 32'd0 && statb == 32'd0) |=> !irq);

  // R3: unused bits of status A stay zero
  always @(negedge clk) begin
    if (rst_n) begin
      a_r3_zero_bits: assert (stata[27:13] == 15'd0 && !stata[31]);
    end
  end

endmodule

bind disp_irq_ctrl dic_checker #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .wdata_b0     (bus_wdata[0]),
  .ev_sof       (ev_sof),
  .ev_eof       (ev_eof),
  .ev_brn       (ev_brn),
  .ev_berr      (ev_berr),
  .ev_berr_ch   (ev_berr_ch),
  .ctrla_en_bit (ctrla_q[0]),
  .stata        (stata),
  .statb        (sb_q),
  .ident        (ident_q),
  .irq          (irq_q)
);

// File: tb/disp_irq_ctrl_bench.sv
module disp_irq_ctrl_bench;
  localparam int PERIOD = 20;
  localparam int NCH    = 7;
  localparam int IDW    = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic b_wr;
  logic [2:0] b_addr;
  logic [31:0] b_wd;
  logic [31:0] rdata;
  logic [NCH-1:0] e_sof, e_eof, e_brn, e_iu;
  logic e_ber;
  logic [2:0] e_berch;
  logic e_ld, e_ab, e_ou, e_rd, e_cm;
  logic [NCH*IDW-1:0] fids;
  logic irq;

  logic [31:0] m_c0, m_c5, m_s0, m_s1, m_id;
  logic m_irq;
  logic [31:0] rv [0:4];
  logic rirq;
  int n_chk = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  disp_irq_ctrl #(.NUM_CH(NCH), .ID_W(IDW)) u_disp_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_addr(b_addr),
    .bus_wdata(b_wd), .bus_rdata(rdata), .ev_sof(e_sof), .ev_eof(e_eof),
    .ev_brn(e_brn), .ev_iu(e_iu), .ev_berr(e_ber), .ev_berr_ch(e_berch),
    .ev_lastdone(e_ld), .ev_acbias(e_ab), .ev_outrun(e_ou), .ev_rdstat(e_rd),
    .ev_cmd(e_cm), .frame_ids(fids), .irq(irq)
  );

  function automatic logic [31:0] fid(input int ch);
    return 32'hA000_0000 + 32'(ch) * 32'h0000_0111;
  endfunction

  function automatic logic level(input logic [31:0] s0, s1, c0, c5);
    return (s0[0] & ~c0[3]) | (s0[1] & ~c0[4]) | s0[2] | (s0[4] & ~c0[5]) |
           (s0[5] & ~c5[24]) | (s0[6] & ~c0[21]) | (s0[7] & ~c0[11]) |
           (s0[8] & ~c0[6]) | (s0[9] & ~c0[20]) | (s0[11] & ~c0[23]) |
           (s0[12] & ~c0[24]) | (|(s1 & ~c5));
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic idle();
    b_wr = 0; b_addr = 0; b_wd = 0;
    e_sof = 0; e_eof = 0; e_brn = 0; e_iu = 0; e_ber = 0; e_berch = 0;
    e_ld = 0; e_ab = 0; e_ou = 0; e_rd = 0; e_cm = 0;
  endtask

  task automatic model_step();
    logic [31:0] n0, n1;
    logic [NCH-1:0] q;
    logic sint;
    logic lv;
    int first;
    if (!rst_n) begin
      m_c0 = 0; m_c5 = 0; m_s0 = 0; m_s1 = 0; m_id = 0; m_irq = 0;
      return;
    end
    lv = level(m_s0, m_s1, m_c0, m_c5);
    q = '0;
    q[0] = (e_sof[0] & ~m_c0[4]) | (e_eof[0] & ~m_c0[6]) | (e_brn[0] & ~m_c0[20]);
    for (int ch = 1; ch < NCH; ch++)
      q[ch] = (e_sof[ch] & ~m_c5[ch-1]) | (e_eof[ch] & ~m_c5[ch+7]) | (e_brn[ch] & ~m_c5[ch+15]);
    if (e_ber) q[e_berch] = 1'b1;
    sint = 0;
    if (|q) begin
      if (m_irq) sint = 1;
      else begin
        first = 0;
        for (int ch = NCH - 1; ch >= 0; ch--) if (q[ch]) first = ch;
        m_id = fid(first);
      end
    end
    n0 = m_s0;
    if (b_wr && b_addr == 3'd2) begin
      n0[11:0] = n0[11:0] & ~b_wd[11:0];
      if (b_wd[2]) n0[30:28] = 3'd0;
    end
    n0[0] |= e_ld; n0[1] |= e_sof[0]; n0[3] |= e_ab; n0[4] |= e_iu[0];
    n0[5] |= e_iu[1]; n0[6] |= e_ou; n0[8] |= e_eof[0]; n0[9] |= e_brn[0];
    n0[10] |= sint; n0[11] |= e_rd; n0[12] |= e_cm;
    n0[7] |= (b_wr && b_addr == 3'd0 && m_c0[0] && !b_wd[0]);
    if (e_ber) begin n0[2] = 1'b1; n0[30:28] = e_berch; end
    n1 = m_s1;
    if (b_wr && b_addr == 3'd3) n1 = n1 & ~(b_wd & 32'h003E_3F3F);
    for (int ch = 1; ch < NCH; ch++) begin
      n1[ch-1] |= e_sof[ch]; n1[ch+7] |= e_eof[ch]; n1[ch+15] |= e_brn[ch];
      if (ch >= 2) n1[ch+23] |= e_iu[ch];
    end
    if (b_wr && b_addr == 3'd0) m_c0 = b_wd & 32'h07FF_FFFF;
    if (b_wr && b_addr == 3'd1) m_c5 = b_wd & 32'h3F3F_3F3F;
    m_s0 = n0; m_s1 = n1; m_irq = lv;
  endtask

  task automatic compare();
    logic [31:0] ex [0:4];
    ex[0] = m_c0; ex[1] = m_c5; ex[2] = m_s0; ex[3] = m_s1; ex[4] = m_id;
    for (int a = 0; a < 5; a++) begin
      b_addr = 3'(a);
      #1;
      rv[a] = rdata;
    end
    rirq = irq;
    chk("R2 control A", rv[0], ex[0]);
    chk("R2 control B", rv[1], ex[1]);
    chk("R3 status A", rv[2], ex[2]);
    chk("R4 status B", rv[3], ex[3]);
    chk("R10 identifier", rv[4], ex[4]);
    chk("R9 irq", 32'(rirq), 32'(m_irq));
    b_addr = 3'd0;
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle();
    compare();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    b_wr = 1; b_addr = a; b_wd = d;
    step();
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int ch = 0; ch < NCH; ch++) fids[ch*IDW +: IDW] = fid(ch);
    idle();
    rst_n = 0;
    void'($urandom(32'd20240611));
    repeat (3) step();
    rst_n = 1;
    for (int a = 0; a < 5; a++) chk("R1 reset value", rv[a], 32'd0);
    chk("R1 reset irq", 32'(rirq), 32'd0);

    wr(3'd0, 32'hFFFF_FFFF);
    chk("R2 control A keep", rv[0], 32'h07FF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    chk("R2 control B keep", rv[1], 32'h3F3F_3F3F);
    wr(3'd0, 32'h0);
    chk("R8 quick disable", rv[2], 32'h0000_0080);
    wr(3'd1, 32'h0);
    chk("R9 irq after unmask", 32'(rirq), 32'd1);
    wr(3'd2, 32'h0000_0FFF);
    step();
    chk("R9 irq drops", 32'(rirq), 32'd0);

    e_ber = 1; e_berch = 3'd5; step();
    chk("R7 bus error field", rv[2], 32'h5000_0004);
    chk("R10 id load", rv[4], fid(5));
    step();
    e_sof[3] = 1; step();
    chk("R4 channel 3 sof", rv[3], 32'h0000_0004);
    chk("R10 subsequent flag", rv[2], 32'h5000_0404);
    chk("R10 id kept", rv[4], fid(5));

    wr(3'd2, 32'h0000_0004);
    chk("R5 clear bit2 and field", rv[2], 32'h0000_0400);
    wr(3'd2, 32'h0000_0FFF);
    e_cm = 1; step();
    wr(3'd2, 32'hFFFF_FFFF);
    chk("R5 bit12 survives", rv[2], 32'h0000_1000);

    wr(3'd3, 32'hFFFF_FFFF);
    chk("R6 clear status B", rv[3], 32'h0);
    e_brn[1] = 1; e_iu[3] = 1; step();
    wr(3'd3, 32'hFFFF_FFFF);
    chk("R6 sticky lanes", rv[3], 32'h0401_0000);

    e_sof[0] = 1; b_wr = 1; b_addr = 3'd2; b_wd = 32'h2; step();
    chk("R12 set beats clear", 32'(rv[2][1]), 32'd1);

    wr(3'd4, 32'h1234_5678);
    chk("R11 identifier read only", rv[4], fid(5));

    wr(3'd1, 32'h3F3F_373D);
    wr(3'd0, 32'h0100_0000);
    wr(3'd2, 32'h0000_0FFF);
    step(); step();
    chk("R9 all masked", 32'(rirq), 32'd0);
    e_sof[2] = 1; e_eof[4] = 1; step();
    chk("R10 lowest channel", rv[4], fid(2));

    wr(3'd3, 32'h0000_0802);
    step(); step();
    wr(3'd0, 32'h0100_0008);
    e_ld = 1; step();
    step(); step();
    chk("R9 masked last-done", 32'(rirq), 32'd0);
    wr(3'd0, 32'h0100_0000);
    step();
    chk("R9 unmasked last-done", 32'(rirq), 32'd1);

    for (int i = 0; i < 3000; i++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        e_sof[ch] = ($urandom % 12) == 0;
        e_eof[ch] = ($urandom % 12) == 0;
        e_brn[ch] = ($urandom % 16) == 0;
        e_iu[ch]  = ($urandom % 16) == 0;
      end
      e_ber = ($urandom % 20) == 0;
      e_berch = 3'($urandom % NCH);
      e_ld = ($urandom % 10) == 0; e_ab = ($urandom % 10) == 0;
      e_ou = ($urandom % 10) == 0; e_rd = ($urandom % 10) == 0;
      e_cm = ($urandom % 40) == 0;
      if (($urandom % 3) == 0) begin
        b_wr = 1;
        b_addr = 3'($urandom % 6);
        b_wd = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom;
      end
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule